// File: doc/BRIEF.md
# Weekday From Date Calculator

This block turns a calendar date in the years 2000 to 2099 into a day-of-week code. A caller presents the day of the month, the month number and the two-digit year together with a one-cycle start strobe. The block latches the date and forms one integer sum in a single cycle. It then reduces that sum modulo seven with a loop that takes one subtraction per clock. When the remainder is ready, the block raises a one-cycle done pulse and the weekday code appears on its output.

The sum starts from the weekday of the first day of 2000. It adds the days elapsed in the current month and one per year since 2000. It adds a fixed per-month offset taken from a common 365-day year, plus one when the year is a leap year and the month is past February. It also adds the number of leap years that came before the given year. The caller must supply a date that exists; the block does not check it.

Top module: `weekday_calc`

## Requirements
- R1: While reset is held, and after it is released with no start, `done` is 0 and `weekday` is 0.
- R2: The weekday code is 0 for Monday, 1 Tuesday, 2 Wednesday, 3 Thursday, 4 Friday, 5 Saturday and 6 Sunday. 1 January 2000 (day 1, month 1, year 0) yields 5.
- R3: The sum S is 5 + (day − 1) + year + M[month] + L + P. M for months 1..12 is 0,3,3,6,1,4,6,2,5,0,3,5. L is 1 when year mod 4 is 0 and month > 2, and 0 otherwise. The reported weekday is S mod 7.
- R4: P is 0 for year 0 and floor((year − 1)/4) + 1 for year ≥ 1, so year 2000 counts as a leap year.
- R5: `done` is high for exactly one cycle per accepted start, and `weekday` is below 7 whenever `done` is high.
- R6: Counting the rising edge that samples `start` as edge 1, `done` is first seen high after edge floor(S/7) + 3.
- R7: A `start` that arrives while a calculation is in progress is ignored. It causes no extra `done`, and the result belongs to the date that was accepted.
- R8: `weekday` holds its value in every cycle in which `done` is low.
- R9: The date inputs are sampled only in the cycle that accepts `start`. Changing them later does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation when idle |
| day | input | 5 | Day of month, 1..31 |
| month | input | 4 | Month, 1..12 |
| year | input | 7 | Year within the century, 0..99 |
| done | output | 1 | One-cycle pulse, result valid |
| weekday | output | 3 | Day of week code, 0 = Monday .. 6 = Sunday |

## Verification
A vector table of known calendar dates covers several cases. Dates before and after 29 February in leap years separate the month-above-February correction from the month offset. The first days of 2000, 2001 and 2004 isolate the leap-count rule around year 0. The last day of 2099 reaches the longest subtraction loop. A sweep over the first day of every month in all hundred years is then compared with a weekday derived by counting elapsed days one month at a time. That comparison is a method independent of the offset table, and each run also checks the latency that the sum predicts. Directed runs hold `start` high while the block is busy and change the date inputs after acceptance, which tells latched inputs apart from live ones.

// File: rtl/weekday_pkg.sv
package weekday_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SUM    = 2'd1,
    ST_REDUCE = 2'd2
  } wd_state_e;

  // Cumulative days before each month of a common year, reduced mod 7.
  function automatic int unsigned month_offset(input int unsigned m);
    case (m)
      1:  return 0;
      2:  return 3;
      3:  return 3;
      4:  return 6;
      5:  return 1;
      6:  return 4;
      7:  return 6;
      8:  return 2;
      9:  return 5;
      10: return 0;
      11: return 3;
      12: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit leap_year(input int unsigned y);
    return (y % 4) == 0;
  endfunction

  // Leap years strictly before year y, counting 2000 itself.
  function automatic int unsigned leaps_before(input int unsigned y);
    if (y == 0) return 0;
    return (y - 1) / 4 + 1;
  endfunction

  function automatic int unsigned raw_sum(input int unsigned d,
                                          input int unsigned m,
                                          input int unsigned y,
                                          input int unsigned epoch);
    int unsigned s;
    s = epoch + (d - 1) + y + month_offset(m) + leaps_before(y);
    if (leap_year(y) && m > 2) s = s + 1;
    return s;
  endfunction

endpackage

// File: rtl/weekday_sum.sv
module weekday_sum #(
  parameter int DAY_W  = 5,
  parameter int MON_W  = 4,
  parameter int YEAR_W = 7,
  parameter int ACC_W  = 8,
  parameter int EPOCH  = 5
) (
  input  logic [DAY_W-1:0]  day_i,
  input  logic [MON_W-1:0]  month_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [ACC_W-1:0]  sum_o
);
  import weekday_pkg::*;

  localparam int unsigned EPOCH_U = EPOCH;

  assign sum_o = ACC_W'(raw_sum(32'(day_i), 32'(month_i), 32'(year_i), EPOCH_U));

endmodule

// File: rtl/weekday_ctrl.sv
module weekday_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic below_i,
  output logic load_o,
  output logic sum_en_o,
  output logic reduce_en_o,
  output logic busy_o
);
  import weekday_pkg::*;

  wd_state_e state_q, state_d;

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign sum_en_o    = (state_q == ST_SUM);
  assign reduce_en_o = (state_q == ST_REDUCE);
  assign busy_o      = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SUM;
      ST_SUM:    state_d = ST_REDUCE;
      ST_REDUCE: if (below_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R5: once the remainder is final the sequencer is free again
  assert_release_after_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reduce_en_o && below_i) |=> !busy_o);

  // R6: the sum cycle always hands over to the reduction loop
  assert_sum_then_reduce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_en_o |=> reduce_en_o);

endmodule

// File: rtl/weekday_reduce.sv
module weekday_reduce #(
  parameter int ACC_W   = 8,
  parameter int WD_W    = 3,
  parameter int MODULUS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_sum_i,
  input  logic             reduce_en_i,
  input  logic [ACC_W-1:0] sum_i,
  output logic             below_o,
  output logic [WD_W-1:0]  weekday_o,
  output logic             done_o
);
  localparam logic [ACC_W-1:0] MOD_V = ACC_W'(MODULUS);

  logic [ACC_W-1:0] acc_q;
  logic             step;
  logic             finish;

  assign below_o = acc_q < MOD_V;
  assign step    = reduce_en_i && !below_o;
  assign finish  = reduce_en_i && below_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (load_sum_i) acc_q <= sum_i;
    else if (step)       acc_q <= acc_q - MOD_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weekday_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) weekday_o <= acc_q[WD_W-1:0];
    end
  end

  // R6: each loop cycle removes exactly one modulus
  assert_step_one_modulus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (acc_q + MOD_V == $past(acc_q)));

  // R5: the result pulse lasts one cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: a reported weekday is a valid code
  assert_weekday_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (weekday_o < WD_W'(MODULUS)));

  // R8: the output holds between results
  assert_weekday_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(weekday_o));

endmodule

// File: rtl/weekday_calc.sv
module weekday_calc #(
  parameter int DAY_W   = 5,
  parameter int MON_W   = 4,
  parameter int YEAR_W  = 7,
  parameter int ACC_W   = 8,
  parameter int WD_W    = 3,
  parameter int EPOCH   = 5,
  parameter int MODULUS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DAY_W-1:0]  day,
  input  logic [MON_W-1:0]  month,
  input  logic [YEAR_W-1:0] year,
  output logic              done,
  output logic [WD_W-1:0]   weekday
);
  localparam int DATE_W = DAY_W + MON_W + YEAR_W;

  logic              load_w, sum_en_w, reduce_en_w, busy_w, below_w;
  logic [DAY_W-1:0]  day_q;
  logic [MON_W-1:0]  month_q;
  logic [YEAR_W-1:0] year_q;
  logic [ACC_W-1:0]  sum_w;
  logic [DATE_W-1:0] date_w;

  assign date_w = {day_q, month_q, year_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q   <= '0;
      month_q <= '0;
      year_q  <= '0;
    end else if (load_w) begin
      day_q   <= day;
      month_q <= month;
      year_q  <= year;
    end
  end

  weekday_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .below_i     (below_w),
    .load_o      (load_w),
    .sum_en_o    (sum_en_w),
    .reduce_en_o (reduce_en_w),
    .busy_o      (busy_w)
  );

  weekday_sum #(
    .DAY_W  (DAY_W),
    .MON_W  (MON_W),
    .YEAR_W (YEAR_W),
    .ACC_W  (ACC_W),
    .EPOCH  (EPOCH)
  ) u_sum (
    .day_i   (day_q),
    .month_i (month_q),
    .year_i  (year_q),
    .sum_o   (sum_w)
  );

  weekday_reduce #(
    .ACC_W   (ACC_W),
    .WD_W    (WD_W),
    .MODULUS (MODULUS)
  ) u_reduce (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_sum_i  (sum_en_w),
    .reduce_en_i (reduce_en_w),
    .sum_i       (sum_w),
    .below_o     (below_w),
    .weekday_o   (weekday),
    .done_o      (done)
  );

  // R7 and R9: the latched date never moves while a calculation runs
  assert_date_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(date_w));

  // R5: the result pulse only follows a calculation
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy_w));

endmodule

// File: tb/weekday_calc_tb.sv
module weekday_calc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] day = 5'd1;
  logic [3:0] month = 4'd1;
  logic [6:0] year = 7'd0;
  logic       done;
  logic [2:0] weekday;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  weekday_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .day(day),
    .month(month), .year(year), .done(done), .weekday(weekday)
  );

  // day, month, year, expected weekday (real calendar)
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {5'd1,  4'd1,  7'd0,  3'd5},   // Sat 2000-01-01
    {5'd29, 4'd2,  7'd0,  3'd1},   // Tue
    {5'd1,  4'd3,  7'd0,  3'd2},   // Wed
    {5'd31, 4'd12, 7'd0,  3'd6},   // Sun
    {5'd1,  4'd1,  7'd1,  3'd0},   // Mon
    {5'd29, 4'd2,  7'd4,  3'd6},   // Sun
    {5'd1,  4'd3,  7'd4,  3'd0},   // Mon
    {5'd4,  4'd7,  7'd20, 3'd5},   // Sat
    {5'd1,  4'd1,  7'd24, 3'd0},   // Mon
    {5'd15, 4'd10, 7'd23, 3'd6},   // Sun
    {5'd31, 4'd12, 7'd99, 3'd3},   // Thu
    {5'd28, 4'd2,  7'd1,  3'd2}    // Wed
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Spec sum (R3, R4) used only to predict latency
  function automatic int spec_sum(int d, int m, int y);
    int offs [12] = '{0, 3, 3, 6, 1, 4, 6, 2, 5, 0, 3, 5};
    int s;
    s = 5 + d - 1 + y + offs[m-1];
    if (y > 0) s += (y - 1) / 4 + 1;
    if ((y % 4 == 0) && m > 2) s += 1;
    return s;
  endfunction

  // Independent weekday: count elapsed days from 2000-01-01
  function automatic int calendar_wd(int d, int m, int y);
    int mlen [12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
    int days = 0;
    for (int i = 0; i < y; i++) days += (i % 4 == 0) ? 366 : 365;
    for (int i = 1; i < m; i++) days += mlen[i-1] + ((i == 2 && y % 4 == 0) ? 1 : 0);
    days += d - 1;
    return (5 + days) % 7;
  endfunction

  task automatic run_date(input int d, input int m, input int y, input int exp_wd,
                          input string tag);
    int lat;
    int exp_lat;
    exp_lat = spec_sum(d, m, y) / 7 + 3;
    day = 5'(d); month = 4'(m); year = 7'(y); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    check(weekday == 3'(exp_wd), {tag, " R2 R3 R4 weekday"}, int'(weekday), exp_wd);
    check(lat == exp_lat, "R6 latency", lat, exp_lat);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", int'(done), 0);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dones;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(weekday == 3'd0, "R1 weekday in reset", int'(weekday), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(weekday == 3'd0, "R1 weekday after reset", int'(weekday), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_date(int'(VEC[i][18:14]), int'(VEC[i][13:10]), int'(VEC[i][9:3]),
               int'(VEC[i][2:0]), "vec");
      check(calendar_wd(int'(VEC[i][18:14]), int'(VEC[i][13:10]), int'(VEC[i][9:3]))
            == int'(VEC[i][2:0]), "R2 table self", 0, 0);
    end

    // Sweep: first day of every month, every year
    for (int y = 0; y < 100; y++)
      for (int m = 1; m <= 12; m++)
        run_date(1, m, y, calendar_wd(1, m, y), "sweep");

    // R8: output holds while idle
    repeat (5) begin
      @(negedge clk);
      check(weekday == 3'(calendar_wd(1, 12, 99)), "R8 hold", int'(weekday),
            calendar_wd(1, 12, 99));
    end

    // R7: starts while busy are ignored
    day = 5'd31; month = 4'd12; year = 7'd99; start = 1'b1;
    @(negedge clk);
    day = 5'd1; month = 4'd1; year = 7'd0;   // start still high while busy
    dones = 0;
    repeat (3) begin
      @(negedge clk);
      if (done) dones++;
    end
    start = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (done) begin
        dones++;
        check(weekday == 3'd3, "R7 result of accepted date", int'(weekday), 3);
      end
    end
    check(dones == 1, "R7 single done", dones, 1);

    // R9: inputs changed after acceptance have no effect
    day = 5'd4; month = 4'd7; year = 7'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    day = 5'd31; month = 4'd12; year = 7'd99;
    while (!done) @(negedge clk);
    check(weekday == 3'd5, "R9 latched inputs", int'(weekday), 5);

    // R1: reset in mid calculation clears outputs
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(weekday == 3'd0 && done == 1'b0, "R1 mid reset", int'(weekday), 0);
    rst_n = 1'b1;
    repeat (200) begin
      @(negedge clk);
      if (done) check(1'b0, "R1 no done after reset", 1, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule